// File: doc/BRIEF.md
# Ones-Counting Unit With One-Hot Controller

This block reports how many bits of a small input word are set. A pulse or level on `start` while the unit is idle captures the word into an internal right-shifting register and clears a result counter. On each later cycle the register moves one place to the right, and the counter advances whenever the bit leaving position 0 is a one. The unit stops as soon as the register holds nothing but zeroes, not after a fixed number of shifts. A word with only low-order ones therefore finishes early.

The unit has a datapath and a controller that share one clock edge. The datapath holds the shift register and the counter, and sends the controller two status lines: the current bit 0 and an all-zero flag. The controller is a three-state machine with one flip-flop per state. It returns load, shift and count enables, plus `done`. The interface is plain level signalling: `start` in, `done` out, with no further handshake. `done` stays high for as long as `start` is held, and the result stays on `count` until the next load.

Top module: `bitcount_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0, `done` becomes 0 and the controller goes idle. `start` is ignored during reset, and a run cut off by reset does not resume.
- R2: When `start` is high at a rising edge in the idle state, `data_in` is copied into the shift register and `count` reads 0 after that edge, even if the previous result was nonzero.
- R3: When `done` rises, `count` (3 bits, unsigned) equals the number of one bits in the loaded word, from 0 to 4. The word 1111 gives 4 with no wrap.
- R4: The controller keeps exactly one of its three state flip-flops set. Count the edge that samples `start` in idle as edge 1, and let L be the position of the highest one bit plus one (L = 0 for 0000). Then `done` first reads 1 after edge L+2.
- R5: While `start` stays high in the finished state, `done` stays 1 and `count` holds. The first edge with `start` low returns the unit to idle: `done` reads 0 and `count` keeps the result.
- R6: Changes on `start` and `data_in` after the loading edge do not affect the run or its result.
- R7: In the idle state with `start` low, `count` holds its value and no load, shift or count takes place.
- R8: In each counting cycle the register shifts right by one, and `count` advances by one exactly when the bit shifted out (bit 0) was 1. After k shifts, `count` equals the number of ones in the k lowest bits of the loaded word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for controller and datapath |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to count the word on `data_in`; sampled in idle |
| data_in | input | 4 | Word whose one bits are counted |
| count | output | 3 | Running and final number of one bits |
| done | output | 1 | High while the result is final, until `start` is released |

## Verification
The hardest situations to reach from the ports are a run that ends in fewer shifts than the word width, and inputs that change while a run is under way. The stimulus covers all sixteen words, so every early stop length from zero to four shifts occurs. It also checks the running count after every shift. During each run, `data_in` is driven with the inverted word, and on alternate words `start` is held high the whole time. This shows that the loaded value alone decides the result. A reset applied in the middle of a run checks that the unit does not resume counting afterwards.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;
  // One-hot state flop positions of the controller
  localparam int ST_N    = 3;
  localparam int ST_IDLE = 0;
  localparam int ST_RUN  = 1;
  localparam int ST_FIN  = 2;

  typedef logic [ST_N-1:0] state_vec_t;

  localparam state_vec_t STV_IDLE = state_vec_t'(1) << ST_IDLE;
  localparam state_vec_t STV_RUN  = state_vec_t'(1) << ST_RUN;
  localparam state_vec_t STV_FIN  = state_vec_t'(1) << ST_FIN;

  // Control bundle from controller to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic incr;
  } dp_ctrl_t;
endpackage

// File: rtl/bitcount_datapath.sv
module bitcount_datapath
  import bitcount_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctrl_t          ctl,
  input  logic [DATA_W-1:0] word_in,
  output logic              lsb,
  output logic              empty,
  output logic [CNT_W-1:0]  tally
);
  localparam logic [CNT_W-1:0] TALLY_MAX = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  tally_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
    end else if (ctl.load) begin
      sreg_q <= word_in;
    end else if (ctl.shift) begin
      sreg_q <= {1'b0, sreg_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q <= '0;
    end else if (ctl.load) begin
      tally_q <= '0;
    end else if (ctl.incr) begin
      tally_q <= tally_q + CNT_W'(1);
    end
  end

  assign lsb   = sreg_q[0];
  assign empty = (sreg_q == '0);
  assign tally = tally_q;

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (tally_q == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ctl.incr |-> (tally_q < TALLY_MAX)); // R3
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (ctl.shift && !ctl.load) |=> (sreg_q == ($past(sreg_q) >> 1))); // R8
  AST_INCR_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
    ctl.incr |-> (ctl.shift && lsb)); // R8
endmodule

// File: rtl/bitcount_ctrl.sv
module bitcount_ctrl
  import bitcount_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go,
  input  logic     lsb,
  input  logic     empty,
  output dp_ctrl_t ctl,
  output logic     fin
);
  state_vec_t state_q, state_d;
  logic       legal;

  // Exactly one bit set
  assign legal = (state_q != '0) && ((state_q & (state_q - state_vec_t'(1))) == '0);

  always_comb begin
    state_d   = state_q;
    ctl.load  = 1'b0;
    ctl.shift = 1'b0;
    ctl.incr  = 1'b0;
    if (!legal) begin
      state_d = STV_IDLE;
    end else if (state_q[ST_IDLE]) begin
      if (go) begin
        ctl.load = 1'b1;
        state_d  = STV_RUN;
      end
    end else if (state_q[ST_RUN]) begin
      if (empty) begin
        state_d = STV_FIN;
      end else begin
        ctl.shift = 1'b1;
        ctl.incr  = lsb;
      end
    end else begin
      if (!go) state_d = STV_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= STV_IDLE;
    else     state_q <= state_d;
  end

  assign fin = state_q[ST_FIN];

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(state_q)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q[ST_IDLE] && !go) |-> !(ctl.load || ctl.shift || ctl.incr)); // R7
  AST_RUN_TO_FIN: assert property (@(posedge clk) disable iff (rst)
    (state_q[ST_RUN] && empty) |=> state_q[ST_FIN]); // R4
  AST_FIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state_q[ST_FIN] && !go) |=> state_q[ST_IDLE]); // R5
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
  import bitcount_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  output logic [CNT_W-1:0]  count,
  output logic              done
);
  dp_ctrl_t ctl;
  logic     lsb, empty;

  bitcount_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .go    (start),
    .lsb   (lsb),
    .empty (empty),
    .ctl   (ctl),
    .fin   (done)
  );

  bitcount_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .word_in (data_in),
    .lsb     (lsb),
    .empty   (empty),
    .tally   (count)
  );

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(count)); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (count == '0 && !done)); // R1
endmodule

// File: tb/bitcount_unit_bench.sv
`timescale 1ns/1ps
module bitcount_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] data_in = 4'h0;
  logic [2:0] count;
  logic       done;

  int nchecks = 0;
  int nfail   = 0;
  int cyc     = 0;
  int exp_cnt_q[$];
  int exp_cyc_q[$];
  int pushed = 0;
  int popped = 0;
  bit done_d = 1'b0;

  always #5 clk = ~clk;

  bitcount_unit u_bitcount_unit (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .count(count), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ones(input logic [3:0] w);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int span(input logic [3:0] w);
    int s = 0;
    for (int i = 0; i < 4; i++) if (w[i]) s = i + 1;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  // Monitor: on each rising done, pop the expected result and its timing
  always @(negedge clk) begin
    if (!rst && done && !done_d) begin
      if (exp_cnt_q.size() == 0) begin
        chk(1'b0, "R4 unexpected done", 1, 0);
      end else begin
        int ec, et;
        ec = exp_cnt_q.pop_front();
        et = exp_cyc_q.pop_front();
        popped++;
        chk(int'(count) == ec, "R3 final count", int'(count), ec);
        chk(cyc == et, "R4 done latency", cyc, et);
      end
    end
    done_d = done;
  end

  // Driver: one full run for word d; hold keeps start high throughout
  task automatic run_word(input logic [3:0] d, input bit hold);
    int k;
    int pc;
    pc = ones(d);
    @(negedge clk);
    start   = 1'b1;
    data_in = d;
    exp_cnt_q.push_back(pc);
    exp_cyc_q.push_back(cyc + 1 + span(d) + 1);
    pushed++;
    k = 0;
    while (!done && k < 12) begin
      @(negedge clk);
      if (done) break;
      if (k == 0)
        chk(count == 3'd0, "R2 count cleared by load", int'(count), 0);
      else
        chk(int'(count) == ones(d & 4'((1 << k) - 1)), "R8 running count",
            int'(count), ones(d & 4'((1 << k) - 1)));
      if (!hold) start = 1'b0;
      data_in = ~d; // R6: data changes mid-run must not matter
      k++;
    end
    chk(int'(count) == pc, "R6 inputs ignored while busy", int'(count), pc);
    if (hold) begin
      repeat (2) begin
        @(negedge clk);
        chk(done == 1'b1, "R5 done held with start", int'(done), 1);
        chk(int'(count) == pc, "R5 count held in done", int'(count), pc);
      end
      start = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b0, "R5 back to idle", int'(done), 0);
    chk(int'(count) == pc, "R5 result kept in idle", int'(count), pc);
    data_in = d ^ 4'hA;
    repeat (2) begin
      @(negedge clk);
      chk(int'(count) == pc && !done, "R7 idle holds", int'(count), pc);
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R1: reset with start asserted
    start   = 1'b1;
    data_in = 4'hF;
    repeat (3) @(negedge clk);
    chk(count == 3'd0, "R1 reset count", int'(count), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst   = 1'b0;
    start = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(count == 3'd0 && !done, "R7 idle after reset", int'(count), 0);
    end

    // R3/R4/R8: every word, alternating how start is driven
    for (int w = 0; w < 16; w++) run_word(4'(w), w[0]);
    // R2: load after a maximal result clears the counter
    run_word(4'hF, 1'b1);
    run_word(4'h5, 1'b0);
    run_word(4'h8, 1'b1);

    // R1: reset in the middle of a run; it must not resume
    @(negedge clk);
    start = 1'b1;
    data_in = 4'hF;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(count == 3'd0, "R1 mid-run reset count", int'(count), 0);
    chk(done == 1'b0, "R1 mid-run reset done", int'(done), 0);
    rst = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(count == 3'd0 && !done, "R1 no resume after reset", int'(count), 0);
    end

    chk(popped == pushed, "R3 all results seen", popped, pushed);
    summary();
    $finish;
  end
endmodule